// File: doc/BRIEF.md
# AC boundary test receiver

This block is a digital model of the test receiver that sits behind one AC-coupled boundary-scan input pin. It takes a pin sample stream that has already been digitized and holds a one-bit hysteresis memory. In AC mode the memory follows only those transitions whose new level persists for a minimum number of sample clocks. Shorter excursions leave it untouched. Before a test, the memory is preloaded from the update stage of the boundary cell. After the test, a capture strobe copies it into the observing cell's capture stage.

Capture alone therefore tells three outcomes apart: a rising edge, a falling edge, and no edge at all. With no edge, the preloaded value comes back unchanged. A 2-bit outcome code reports which of the three happened. In DC mode the receiver captures the pin level directly, as an ordinary level-sensitive input would. Each leg of a differential pair gets its own instance. A parameter marks the minus leg, whose sample is inverted before use.

Top module: `boundary_ac_rx`

## Requirements
- R1: A synchronous reset clears the hysteresis memory to 0, the sustain counter to 0, `capture_o` to 0 and `outcome_o` to 0 (none).
- R2: In AC mode, a pin level that differs from the memory on SUSTAIN consecutive sample clocks is written into the memory. The outcome becomes rise (code 1) for a new level of 1 and fall (code 2) for a new level of 0. Code 3 never appears.
- R3: In AC mode, an excursion shorter than SUSTAIN sample clocks leaves both the memory and the outcome unchanged.
- R4: The sustain count restarts from zero whenever the pin returns to the memory value, so an interrupted excursion must again last a full SUSTAIN clocks.
- R5: A preload strobe writes `preload_val_i` into the memory and sets the outcome to none. With no later valid edge, the next capture returns the preloaded value with outcome none.
- R6: A preload in the same cycle as an edge that would complete takes priority: the memory takes the preload value and the outcome is none.
- R7: In DC mode, a capture stores the pin level sampled in the capture cycle, with outcome none. The pin does not alter the hysteresis memory while DC mode is selected.
- R8: With INVERT_LEG set, the receiver works on the complement of `pin_i` in both modes.
- R9: `capture_o` and `outcome_o` change only on a capture strobe (or reset).
- R10: In AC mode, each valid edge after a preload overwrites the memory, so the capture reports the direction of the last valid edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| ac_mode_i | input | 1 | 1 = transition capture, 0 = level capture |
| pin_i | input | 1 | Digitized pin sample |
| preload_i | input | 1 | Preload strobe for the hysteresis memory |
| preload_val_i | input | 1 | Value from the boundary cell update stage |
| capture_i | input | 1 | Capture strobe of the observing cell |
| capture_o | output | 1 | Capture stage contents |
| outcome_o | output | 2 | Outcome at last capture: 0 none, 1 rise, 2 fall |

## Verification
Directed runs separate a clean rising edge and a clean falling edge from two kinds of short pulse. One is a pulse one clock shy of SUSTAIN. The other is a pulse interrupted by a single clock back at the memory value, which shows whether the count restarts. A preload that collides with a completing edge checks priority. A DC-mode stretch of the opposite level checks that the memory is left alone. A second instance with the inverted leg shows the complement in both modes. Random pin runs of one to seven clocks, mixed with random preloads, captures and mode changes, are compared cycle by cycle with a bench model for both legs.

// File: rtl/rx_ac_pkg.sv
package rx_ac_pkg;
   typedef enum logic [1:0] {
      OUT_NONE = 2'd0,
      OUT_RISE = 2'd1,
      OUT_FALL = 2'd2
   } rx_outcome_e;
endpackage

// File: rtl/rx_leg_cond.sv
module rx_leg_cond #(
   parameter bit INVERT = 1'b0
) (
   input  logic pin_i,
   output logic pin_o
);
   generate
      if (INVERT) begin : g_minus
         assign pin_o = ~pin_i;
      end else begin : g_plus
         assign pin_o = pin_i;
      end
   endgenerate
endmodule

// File: rtl/rx_sustain_filter.sv
module rx_sustain_filter
   import rx_ac_pkg::*;
#(
   parameter int unsigned SUSTAIN = 4
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        ac_mode_i,
   input  logic        pin_i,
   input  logic        preload_i,
   input  logic        preload_val_i,
   output logic        mem_o,
   output rx_outcome_e edge_o
);
   localparam int unsigned CNT_W = (SUSTAIN > 1) ? $clog2(SUSTAIN) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SUSTAIN - 1);

   generate
      if (SUSTAIN < 1) begin : g_bad_sustain
         $error("rx_sustain_filter: SUSTAIN must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             mem_q;
   rx_outcome_e      edge_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         mem_q  <= 1'b0;
         cnt_q  <= '0;
         edge_q <= OUT_NONE;
      end else if (preload_i) begin
         mem_q  <= preload_val_i;
         cnt_q  <= '0;
         edge_q <= OUT_NONE;
      end else if (!ac_mode_i || (pin_i == mem_q)) begin
         cnt_q  <= '0;
      end else if (cnt_q == LAST) begin
         mem_q  <= pin_i;
         cnt_q  <= '0;
         edge_q <= pin_i ? OUT_RISE : OUT_FALL;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign mem_o  = mem_q;
   assign edge_o = edge_q;
endmodule

// File: rtl/rx_capture_stage.sv
module rx_capture_stage
   import rx_ac_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        capture_i,
   input  logic        ac_mode_i,
   input  logic        pin_i,
   input  logic        mem_i,
   input  rx_outcome_e edge_i,
   output logic        cap_o,
   output rx_outcome_e out_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         cap_o <= 1'b0;
         out_o <= OUT_NONE;
      end else if (capture_i) begin
         if (ac_mode_i) begin
            cap_o <= mem_i;
            out_o <= edge_i;
         end else begin
            cap_o <= pin_i;
            out_o <= OUT_NONE;
         end
      end
   end
endmodule

// File: rtl/boundary_ac_rx.sv
module boundary_ac_rx
   import rx_ac_pkg::*;
#(
   parameter int unsigned SUSTAIN    = 4,
   parameter bit          INVERT_LEG = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       ac_mode_i,
   input  logic       pin_i,
   input  logic       preload_i,
   input  logic       preload_val_i,
   input  logic       capture_i,
   output logic       capture_o,
   output logic [1:0] outcome_o
);
   logic        pin_s;
   logic        mem_q;
   rx_outcome_e edge_w;
   rx_outcome_e out_w;

   rx_leg_cond #(.INVERT(INVERT_LEG)) u_leg (
      .pin_i (pin_i),
      .pin_o (pin_s)
   );

   rx_sustain_filter #(.SUSTAIN(SUSTAIN)) u_filt (
      .clk           (clk),
      .rst           (rst),
      .ac_mode_i     (ac_mode_i),
      .pin_i         (pin_s),
      .preload_i     (preload_i),
      .preload_val_i (preload_val_i),
      .mem_o         (mem_q),
      .edge_o        (edge_w)
   );

   rx_capture_stage u_cap (
      .clk       (clk),
      .rst       (rst),
      .capture_i (capture_i),
      .ac_mode_i (ac_mode_i),
      .pin_i     (pin_s),
      .mem_i     (mem_q),
      .edge_i    (edge_w),
      .cap_o     (capture_o),
      .out_o     (out_w)
   );

   assign outcome_o = out_w;
endmodule

// File: rtl/boundary_ac_rx_chk.sv
module boundary_ac_rx_chk #(
   parameter int unsigned SUSTAIN    = 4,
   parameter bit          INVERT_LEG = 1'b0
) (
   input logic       clk,
   input logic       rst,
   input logic       ac_mode_i,
   input logic       pin_i,
   input logic       preload_i,
   input logic       preload_val_i,
   input logic       capture_i,
   input logic       capture_o,
   input logic [1:0] outcome_o,
   input logic       mem_q
);
   logic        pin_c;
   logic [31:0] run_q;

   assign pin_c = INVERT_LEG ? ~pin_i : pin_i;

   // independent count of consecutive differing AC-mode samples
   always_ff @(posedge clk) begin
      if (rst) run_q <= '0;
      else if (ac_mode_i && !preload_i && (pin_c != mem_q))
         run_q <= (run_q == 32'hFFFF_FFFF) ? run_q : run_q + 1'b1;
      else run_q <= '0;
   end

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (capture_o == 1'b0) && (outcome_o == 2'd0) && (mem_q == 1'b0));

   a_r2_legal_code: assert property (@(posedge clk) disable iff (rst)
      outcome_o != 2'd3);

   a_r3_min_sustain: assert property (@(posedge clk) disable iff (rst)
      (mem_q != $past(mem_q)) && !$past(preload_i) && !$past(rst)
      |-> ($past(run_q) + 32'd1 >= 32'(SUSTAIN)));

   a_r5_preload_loads: assert property (@(posedge clk) disable iff (rst)
      preload_i |=> mem_q == $past(preload_val_i));

   a_r7_dc_level: assert property (@(posedge clk) disable iff (rst)
      capture_i && !ac_mode_i |=> (capture_o == $past(pin_c)) && (outcome_o == 2'd0));

   a_r7_dc_keeps_mem: assert property (@(posedge clk) disable iff (rst)
      !ac_mode_i && !preload_i |=> $stable(mem_q));

   a_r9_hold_outputs: assert property (@(posedge clk) disable iff (rst)
      !capture_i |=> $stable(capture_o) && $stable(outcome_o));
endmodule

bind boundary_ac_rx boundary_ac_rx_chk #(
   .SUSTAIN    (SUSTAIN),
   .INVERT_LEG (INVERT_LEG)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .ac_mode_i     (ac_mode_i),
   .pin_i         (pin_i),
   .preload_i     (preload_i),
   .preload_val_i (preload_val_i),
   .capture_i     (capture_i),
   .capture_o     (capture_o),
   .outcome_o     (outcome_o),
   .mem_q         (mem_q)
);

// File: tb/sim_boundary_ac_rx.sv
module sim_boundary_ac_rx;
   localparam int unsigned S = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ac = 1'b0, pin = 1'b0, pre = 1'b0, pre_val = 1'b0, cap = 1'b0;
   logic       cap_o0, cap_o1;
   logic [1:0] out_o0, out_o1;

   int checks = 0;
   int fails  = 0;

   // bench model state, one slot per leg
   bit       m_mem [2];
   int       m_cnt [2];
   bit [1:0] m_edge[2];
   bit       m_cap [2];
   bit [1:0] m_out [2];

   always #10 clk = ~clk;

   boundary_ac_rx #(.SUSTAIN(S), .INVERT_LEG(1'b0)) u0 (
      .clk(clk), .rst(rst), .ac_mode_i(ac), .pin_i(pin), .preload_i(pre),
      .preload_val_i(pre_val), .capture_i(cap), .capture_o(cap_o0), .outcome_o(out_o0));

   boundary_ac_rx #(.SUSTAIN(S), .INVERT_LEG(1'b1)) u1 (
      .clk(clk), .rst(rst), .ac_mode_i(ac), .pin_i(pin), .preload_i(pre),
      .preload_val_i(pre_val), .capture_i(cap), .capture_o(cap_o1), .outcome_o(out_o1));

   function automatic bit [1:0] dir_code(bit lvl);
      return lvl ? 2'd1 : 2'd2;
   endfunction

   function automatic bit leg_level(bit p, int leg);
      return (leg == 1) ? ~p : p;
   endfunction

   task automatic model_step();
      for (int leg = 0; leg < 2; leg++) begin
         bit ps;
         ps = leg_level(pin, leg);
         if (rst) begin
            m_mem[leg] = 0; m_cnt[leg] = 0; m_edge[leg] = 0; m_cap[leg] = 0; m_out[leg] = 0;
         end else begin
            if (cap) begin
               if (ac) begin m_cap[leg] = m_mem[leg]; m_out[leg] = m_edge[leg]; end
               else    begin m_cap[leg] = ps;         m_out[leg] = 2'd0;         end
            end
            if (pre) begin
               m_mem[leg] = pre_val; m_cnt[leg] = 0; m_edge[leg] = 2'd0;
            end else if (!ac || ps == m_mem[leg]) begin
               m_cnt[leg] = 0;
            end else if (m_cnt[leg] == int'(S) - 1) begin
               m_mem[leg] = ps; m_cnt[leg] = 0; m_edge[leg] = dir_code(ps);
            end else begin
               m_cnt[leg] = m_cnt[leg] + 1;
            end
         end
      end
   endtask

   task automatic tick();
      model_step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cmp_model(string tag);
      check({tag, " leg0 cap"}, {1'b0, cap_o0}, {1'b0, m_cap[0]});
      check({tag, " leg0 out"}, out_o0, m_out[0]);
      check({tag, " leg1 cap"}, {1'b0, cap_o1}, {1'b0, m_cap[1]});
      check({tag, " leg1 out"}, out_o1, m_out[1]);
   endtask

   task automatic drive(bit p, int n);
      pin = p;
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic do_cap();
      cap = 1'b1; tick(); cap = 1'b0;
   endtask

   task automatic do_pre(bit v);
      pre = 1'b1; pre_val = v; tick(); pre = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      #(200000 * 20);
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      @(posedge clk); #1;
      tick(); tick();
      check("R1 reset capture", {1'b0, cap_o0}, 2'd0);
      check("R1 reset outcome", out_o0, 2'd0);
      rst = 1'b0;
      ac = 1'b1; pin = 1'b0;
      do_cap();
      check("R1 memory zero after reset", {1'b0, cap_o0}, 2'd0);
      check("R1 no edge after reset", out_o0, 2'd0);

      // R2 clean rising edge after preload 0
      do_pre(1'b0);
      drive(1'b1, S);
      do_cap();
      check("R2 rise level", {1'b0, cap_o0}, 2'd1);
      check("R2 rise code", out_o0, 2'd1);
      check("R8 minus leg sees no edge", {1'b0, cap_o1}, 2'd0);
      check("R8 minus leg none", out_o1, 2'd0);

      // R3/R5 short excursion keeps preloaded value
      do_pre(1'b1);
      drive(1'b0, S - 1);
      pin = 1'b1;
      do_cap();
      check("R3 glitch ignored level", {1'b0, cap_o0}, 2'd1);
      check("R5 preload none", out_o0, 2'd0);

      // R4 interrupted excursion restarts the count
      drive(1'b0, S - 1);
      drive(1'b1, 1);
      drive(1'b0, S - 1);
      pin = 1'b1;
      do_cap();
      check("R4 restart level", {1'b0, cap_o0}, 2'd1);
      check("R4 restart none", out_o0, 2'd0);
      drive(1'b0, S);
      do_cap();
      check("R2 fall level", {1'b0, cap_o0}, 2'd0);
      check("R2 fall code", out_o0, 2'd2);

      // R6 preload collides with completing edge
      drive(1'b1, S - 1);
      pre = 1'b1; pre_val = 1'b1; tick(); pre = 1'b0;
      do_cap();
      check("R6 preload wins level", {1'b0, cap_o0}, 2'd1);
      check("R6 preload wins code", out_o0, 2'd0);

      // R10 last edge wins
      do_pre(1'b0);
      drive(1'b1, S);
      drive(1'b0, S);
      do_cap();
      check("R10 last edge level", {1'b0, cap_o0}, 2'd0);
      check("R10 last edge code", out_o0, 2'd2);

      // R9 outputs hold while an edge commits without capture
      drive(1'b1, S + 2);
      check("R9 hold level", {1'b0, cap_o0}, 2'd0);
      check("R9 hold code", out_o0, 2'd2);
      do_cap();
      check("R10 overwrite level", {1'b0, cap_o0}, 2'd1);
      check("R10 overwrite code", out_o0, 2'd1);

      // R7 DC mode level capture; memory untouched
      ac = 1'b0; pin = 1'b0;
      do_cap();
      check("R7 dc low", {1'b0, cap_o0}, 2'd0);
      check("R7 dc none", out_o0, 2'd0);
      check("R8 dc minus leg", {1'b0, cap_o1}, 2'd1);
      drive(1'b1, 2);
      do_cap();
      check("R7 dc high", {1'b0, cap_o0}, 2'd1);
      check("R8 dc minus leg low", {1'b0, cap_o1}, 2'd0);
      drive(1'b0, S + 3);
      ac = 1'b1;
      do_cap();
      check("R7 dc left memory", {1'b0, cap_o0}, 2'd1);
      check("R7 dc left edge", out_o0, 2'd1);
      cmp_model("R8 directed model");

      // random phase against the model
      for (int i = 0; i < 3000; ) begin
         int run;
         pin = 1'($urandom_range(0, 1));
         run = int'($urandom_range(1, 7));
         for (int k = 0; k < run; k++) begin
            pre     = ($urandom_range(0, 15) == 0);
            pre_val = 1'($urandom_range(0, 1));
            cap     = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 63) == 0) ac = ~ac;
            tick();
            cmp_model("R2 R9 random");
            i++;
         end
      end
      pre = 1'b0; cap = 1'b0;

      summary();
      $finish;
   end
endmodule